// File: doc/BRIEF.md
# Port Status LED Driver

This block turns the status of a two-port media converter (one twisted-pair port, one fiber port) into levels for a row of status lamps. Each lamp pin is driven low to light it. The twisted-pair port has lamps for link and activity, for speed, and for duplex and collisions. The fiber port has lamps for link and activity, for duplex and collisions, and for signal detect. One more lamp shows that a far-end-fault pattern is being received.

Link and duplex lamps show a steady level. Activity or collision pulses lay a short-on, long-off flash over that level. The fault lamp uses the reverse duty: it is long on and briefly off. All timing comes from an internal millisecond tick. The tick is divided down from the block clock, and a parameter sets the divider, so a short value can be used in simulation. The status inputs are expected to be debounced and synchronous to the clock already.

Top module: `port_led_driver`

## Requirements
- R1: Every lamp output is active low: 0 lights the lamp. During and right after reset, with all status inputs at 0, all seven outputs are 1.
- R2: A link lamp is lit while its link input is 1 and there is no flash. It is dark in the same cycle that the link input is 0.
- R3: An activity pulse while the link is up starts one flash period. The lamp stays lit for about FLASH_ON_MS ms: after the pulse, the dark phase begins between (FLASH_ON_MS-1)*CYC_PER_MS+2 and FLASH_ON_MS*CYC_PER_MS+1 cycles. The lamp is then dark for exactly FLASH_OFF_MS*CYC_PER_MS cycles, and after that it is steadily lit again.
- R4: An activity pulse that arrives while a flash period is running adds one more complete period. That period starts right after the current one, with an on phase of exactly FLASH_ON_MS*CYC_PER_MS cycles and then a dark phase of FLASH_OFF_MS*CYC_PER_MS cycles.
- R5: Dropping a link cancels any flash on its lamp at once. When the link returns, the lamp is steadily lit with no leftover flash.
- R6: A duplex lamp is lit for full duplex (input 1) and dark for half duplex (input 0). In half duplex, a collision pulse lights it for between (FLASH_ON_MS-1)*CYC_PER_MS+1 and FLASH_ON_MS*CYC_PER_MS cycles, and then it is dark again. In full duplex, a collision pulse has no visible effect.
- R7: The speed lamp is lit when the speed input is 1 (100 Mb/s) and dark when it is 0 (10 Mb/s).
- R8: The signal-detect lamp is lit while the fiber signal input is 1 and dark while it is 0.
- R9: While the fault input is 1, the fault lamp repeats a cycle that begins with its lit phase. The first lit phase is between (FEF_ON_MS-1)*CYC_PER_MS+1 and FEF_ON_MS*CYC_PER_MS cycles long. After it, dark phases last exactly FEF_OFF_MS*CYC_PER_MS cycles and lit phases exactly FEF_ON_MS*CYC_PER_MS cycles. When the fault input goes to 0, the lamp goes dark in the same cycle.
- R10: An activity pulse received while the link is down is ignored: when the link comes up, the lamp is steadily lit.
- R11: The fiber link and fiber duplex lamps follow the same flash rules (R3, R6) as the twisted-pair lamps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (25 MHz in use) |
| rst_n | input | 1 | Active-low synchronous reset |
| tp_link | input | 1 | Twisted-pair link up |
| tp_speed100 | input | 1 | Twisted-pair speed, 1 = 100 Mb/s |
| tp_full | input | 1 | Twisted-pair full duplex |
| tp_act | input | 1 | Twisted-pair activity pulse |
| tp_col | input | 1 | Twisted-pair collision pulse |
| fx_link | input | 1 | Fiber link up |
| fx_full | input | 1 | Fiber full duplex |
| fx_act | input | 1 | Fiber activity pulse |
| fx_col | input | 1 | Fiber collision pulse |
| fx_sig | input | 1 | Fiber signal present |
| fx_fef | input | 1 | Far-end-fault pattern being received |
| led_tp_link_n | output | 1 | Twisted-pair link/activity lamp, active low |
| led_tp_spd_n | output | 1 | Twisted-pair speed lamp, active low |
| led_tp_dup_n | output | 1 | Twisted-pair duplex/collision lamp, active low |
| led_fx_link_n | output | 1 | Fiber link/activity lamp, active low |
| led_fx_dup_n | output | 1 | Fiber duplex/collision lamp, active low |
| led_fx_sd_n | output | 1 | Fiber signal-detect lamp, active low |
| led_fef_n | output | 1 | Far-end-fault lamp, active low |

## Verification
Each flash unit holds a phase flag, a tick counter and a pending-repeat flag. If the counter or the phase is wrong, the lit or dark phase has the wrong length, and that shows on the pin within one flash period of about 100 ms. A pending flag that is stuck or lost shows as an extra or a missing flash period right after the current one ends. A cancel that does not take effect when a link drops or a duplex mode changes shows as a leftover dark phase as soon as the link returns. The bench measures every phase length in clock cycles, so an error in the tick divider of even one cycle shows up in the first measured dark phase.

// File: rtl/port_led_pkg.sv
package port_led_pkg;

   localparam int NUM_FLASH = 4;

   typedef enum logic [1:0] {
      CH_TP_LINK = 2'd0,
      CH_TP_DUP  = 2'd1,
      CH_FX_LINK = 2'd2,
      CH_FX_DUP  = 2'd3
   } flash_ch_e;

   typedef enum logic {
      PH_LIT  = 1'b0,
      PH_DARK = 1'b1
   } flash_phase_e;

   // Link-style channels: steady lit, flash darkens.
   // Duplex-style channels: steady dark in half duplex, flash lights.
   function automatic bit ch_is_link(input int idx);
      return (idx == int'(CH_TP_LINK)) || (idx == int'(CH_FX_LINK));
   endfunction

endpackage

// File: rtl/ms_tick_gen.sv
module ms_tick_gen #(
   parameter int CYC_PER_MS = 25000
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int CW = $clog2(CYC_PER_MS + 1);

   generate
      if (CYC_PER_MS < 1) begin : g_bad_div
         $error("CYC_PER_MS must be at least 1");
      end
   endgenerate

   logic [CW-1:0] div_q;

   assign tick = (div_q == CW'(CYC_PER_MS - 1));

   always_ff @(posedge clk) begin
      if (!rst_n)
         div_q <= '0;
      else if (tick)
         div_q <= '0;
      else
         div_q <= div_q + 1'b1;
   end

   // R3: divider never leaves its range
   a_r3_div_range: assert property (@(posedge clk) disable iff (!rst_n)
      div_q < CW'(CYC_PER_MS));

endmodule

// File: rtl/flash_seq.sv
module flash_seq #(
   parameter int ON_TICKS  = 20,
   parameter int OFF_TICKS = 80
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic run,
   input  logic trig,
   output logic active,
   output logic lit_phase
);
   import port_led_pkg::*;

   localparam int MAXT = (ON_TICKS > OFF_TICKS) ? ON_TICKS : OFF_TICKS;
   localparam int CW   = $clog2(MAXT + 1);

   generate
      if (ON_TICKS < 1 || OFF_TICKS < 1) begin : g_bad_len
         $error("flash phase lengths must be at least 1 tick");
      end
   endgenerate

   logic          act_q;
   flash_phase_e  ph_q;
   logic [CW-1:0] cnt_q;
   logic          pend_q;

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         act_q  <= 1'b0;
         ph_q   <= PH_LIT;
         cnt_q  <= '0;
         pend_q <= 1'b0;
      end else if (!act_q) begin
         if (trig) begin
            act_q  <= 1'b1;
            ph_q   <= PH_LIT;
            cnt_q  <= '0;
            pend_q <= 1'b0;
         end
      end else begin
         if (trig)
            pend_q <= 1'b1;
         if (tick) begin
            if (ph_q == PH_LIT) begin
               if (cnt_q == CW'(ON_TICKS - 1)) begin
                  ph_q  <= PH_DARK;
                  cnt_q <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end else begin
               if (cnt_q == CW'(OFF_TICKS - 1)) begin
                  ph_q   <= PH_LIT;
                  cnt_q  <= '0;
                  pend_q <= 1'b0;
                  act_q  <= pend_q | trig;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
         end
      end
   end

   assign active    = act_q;
   assign lit_phase = (ph_q == PH_LIT);

   // R5: cancel wins over everything
   a_r5_cancel: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !active);

   // R3: a new period always opens with its lit phase
   a_r3_open_lit: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(active) |-> lit_phase);

   // R4: tick counter stays inside the longer phase
   a_r4_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < CW'(MAXT));

   // R4: a repeat request only exists inside a running period
   a_r4_pend_active: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q |-> act_q);

endmodule

// File: rtl/port_led_driver.sv
module port_led_driver #(
   parameter int CYC_PER_MS   = 25000,
   parameter int FLASH_ON_MS  = 20,
   parameter int FLASH_OFF_MS = 80,
   parameter int FEF_ON_MS    = 80,
   parameter int FEF_OFF_MS   = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tp_link,
   input  logic tp_speed100,
   input  logic tp_full,
   input  logic tp_act,
   input  logic tp_col,
   input  logic fx_link,
   input  logic fx_full,
   input  logic fx_act,
   input  logic fx_col,
   input  logic fx_sig,
   input  logic fx_fef,
   output logic led_tp_link_n,
   output logic led_tp_spd_n,
   output logic led_tp_dup_n,
   output logic led_fx_link_n,
   output logic led_fx_dup_n,
   output logic led_fx_sd_n,
   output logic led_fef_n
);
   import port_led_pkg::*;

   logic                 ms_tick;
   logic [NUM_FLASH-1:0] ch_run;
   logic [NUM_FLASH-1:0] ch_trig;
   logic [NUM_FLASH-1:0] ch_act;
   logic [NUM_FLASH-1:0] ch_on;
   logic [NUM_FLASH-1:0] ch_lit;
   logic                 fef_act;
   logic                 fef_on;

   ms_tick_gen #(.CYC_PER_MS(CYC_PER_MS)) tick_i (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (ms_tick)
   );

   // run is the steady condition under which a flash may show
   assign ch_run[CH_TP_LINK]  = tp_link;
   assign ch_run[CH_TP_DUP]   = ~tp_full;
   assign ch_run[CH_FX_LINK]  = fx_link;
   assign ch_run[CH_FX_DUP]   = ~fx_full;
   assign ch_trig[CH_TP_LINK] = tp_act;
   assign ch_trig[CH_TP_DUP]  = tp_col;
   assign ch_trig[CH_FX_LINK] = fx_act;
   assign ch_trig[CH_FX_DUP]  = fx_col;

   generate
      for (genvar i = 0; i < NUM_FLASH; i++) begin : g_ch
         flash_seq #(
            .ON_TICKS  (FLASH_ON_MS),
            .OFF_TICKS (FLASH_OFF_MS)
         ) seq_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick      (ms_tick),
            .run       (ch_run[i]),
            .trig      (ch_trig[i]),
            .active    (ch_act[i]),
            .lit_phase (ch_on[i])
         );
         if (ch_is_link(i)) begin : g_link_style
            assign ch_lit[i] = ch_run[i] & ~(ch_act[i] & ~ch_on[i]);
         end else begin : g_dup_style
            assign ch_lit[i] = ~ch_run[i] | (ch_act[i] & ch_on[i]);
         end
      end
   endgenerate

   flash_seq #(
      .ON_TICKS  (FEF_ON_MS),
      .OFF_TICKS (FEF_OFF_MS)
   ) fef_seq_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (ms_tick),
      .run       (fx_fef),
      .trig      (fx_fef),
      .active    (fef_act),
      .lit_phase (fef_on)
   );

   assign led_tp_link_n = ~ch_lit[CH_TP_LINK];
   assign led_tp_dup_n  = ~ch_lit[CH_TP_DUP];
   assign led_fx_link_n = ~ch_lit[CH_FX_LINK];
   assign led_fx_dup_n  = ~ch_lit[CH_FX_DUP];
   assign led_tp_spd_n  = ~tp_speed100;
   assign led_fx_sd_n   = ~fx_sig;
   assign led_fef_n     = ~(fx_fef & fef_act & fef_on);

   // R2: link down forces the link lamps dark
   a_r2_tp_link_dark: assert property (@(posedge clk) disable iff (!rst_n)
      !tp_link |-> led_tp_link_n);
   a_r2_fx_link_dark: assert property (@(posedge clk) disable iff (!rst_n)
      !fx_link |-> led_fx_link_n);

   // R6: full duplex always lights the duplex lamp
   a_r6_tp_full_lit: assert property (@(posedge clk) disable iff (!rst_n)
      tp_full |-> !led_tp_dup_n);

   // R10: a link that has just come up shows steady lit
   a_r10_link_up_lit: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tp_link) |-> !led_tp_link_n);

   // R9: no fault input, no fault lamp
   a_r9_fef_dark: assert property (@(posedge clk) disable iff (!rst_n)
      !fx_fef |-> led_fef_n);

endmodule

// File: tb/port_led_driver_tb_top.sv
module port_led_driver_tb_top;

   localparam int CPM  = 4;
   localparam int F_ON = 20;
   localparam int F_OF = 80;
   localparam int E_ON = 80;
   localparam int E_OF = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tp_link = 0, tp_speed100 = 0, tp_full = 0, tp_act = 0, tp_col = 0;
   logic fx_link = 0, fx_full = 0, fx_act = 0, fx_col = 0, fx_sig = 0, fx_fef = 0;
   logic led_tp_link_n, led_tp_spd_n, led_tp_dup_n;
   logic led_fx_link_n, led_fx_dup_n, led_fx_sd_n, led_fef_n;

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   always #2.5 clk = ~clk;

   port_led_driver #(
      .CYC_PER_MS(CPM), .FLASH_ON_MS(F_ON), .FLASH_OFF_MS(F_OF),
      .FEF_ON_MS(E_ON), .FEF_OFF_MS(E_OF)
   ) dut_i (
      .clk(clk), .rst_n(rst_n),
      .tp_link(tp_link), .tp_speed100(tp_speed100), .tp_full(tp_full),
      .tp_act(tp_act), .tp_col(tp_col),
      .fx_link(fx_link), .fx_full(fx_full), .fx_act(fx_act), .fx_col(fx_col),
      .fx_sig(fx_sig), .fx_fef(fx_fef),
      .led_tp_link_n(led_tp_link_n), .led_tp_spd_n(led_tp_spd_n),
      .led_tp_dup_n(led_tp_dup_n), .led_fx_link_n(led_fx_link_n),
      .led_fx_dup_n(led_fx_dup_n), .led_fx_sd_n(led_fx_sd_n),
      .led_fef_n(led_fef_n)
   );

   localparam int S_TPL = 0, S_TPD = 1, S_FXL = 2, S_FXD = 3, S_FEF = 4;

   function automatic logic pin(input int s);
      case (s)
         S_TPL:   return led_tp_link_n;
         S_TPD:   return led_tp_dup_n;
         S_FXL:   return led_fx_link_n;
         S_FXD:   return led_fx_dup_n;
         default: return led_fef_n;
      endcase
   endfunction

   task automatic chk(input string req, input int act, input int lo, input int hi);
      checks++;
      if (act < lo || act > hi) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
      end
   endtask

   // number of negedges while pin stays at lvl (capped)
   task automatic run_len(input int s, input logic lvl, input int maxc, output int n);
      n = 0;
      while (pin(s) == lvl && n < maxc) begin
         @(negedge clk);
         n++;
      end
   endtask

   // number of negedges until pin reaches lvl (capped)
   task automatic wait_lvl(input int s, input logic lvl, input int maxc, output int k);
      k = 0;
      while (pin(s) != lvl && k < maxc) begin
         @(negedge clk);
         k++;
      end
   endtask

   task automatic pulse_act(input bit fiber);
      @(negedge clk);
      if (fiber) fx_act = 1; else tp_act = 1;
      @(negedge clk);
      fx_act = 0; tp_act = 0;
   endtask

   task automatic pulse_col(input bit fiber);
      @(negedge clk);
      if (fiber) fx_col = 1; else tp_col = 1;
      @(negedge clk);
      fx_col = 0; tp_col = 0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic t_reset;
      idle(3);
      chk("R1 reset tp_link", led_tp_link_n, 1, 1);
      chk("R1 reset pins", {led_tp_spd_n, led_tp_dup_n, led_fx_link_n,
          led_fx_dup_n, led_fx_sd_n, led_fef_n}, 6'h3f, 6'h3f);
      rst_n = 1;
      idle(5);
      chk("R1 after reset pins", {led_tp_link_n, led_tp_spd_n, led_tp_dup_n,
          led_fx_link_n, led_fx_dup_n, led_fx_sd_n, led_fef_n}, 7'h7f, 7'h7f);
   endtask

   task automatic t_static;
      tp_link = 1; tp_speed100 = 1; fx_sig = 1; tp_full = 1;
      #1;
      chk("R2 link up lit", led_tp_link_n, 0, 0);
      chk("R7 speed 100 lit", led_tp_spd_n, 0, 0);
      chk("R8 signal lit", led_fx_sd_n, 0, 0);
      chk("R6 full lit", led_tp_dup_n, 0, 0);
      idle(2);
      tp_speed100 = 0; fx_sig = 0; tp_full = 0;
      #1;
      chk("R7 speed 10 dark", led_tp_spd_n, 1, 1);
      chk("R8 no signal dark", led_fx_sd_n, 1, 1);
      chk("R6 half dark", led_tp_dup_n, 1, 1);
      tp_link = 0;
      #1;
      chk("R2 link down dark", led_tp_link_n, 1, 1);
      idle(2);
   endtask

   task automatic t_act(input bit fiber, input string req);
      int k, n;
      int s = fiber ? S_FXL : S_TPL;
      if (fiber) fx_link = 1; else tp_link = 1;
      idle(7);
      pulse_act(fiber);
      wait_lvl(s, 1'b1, 2000, k);
      chk({req, " dark start"}, k + 1, (F_ON-1)*CPM + 2, F_ON*CPM + 1);
      run_len(s, 1'b1, 2000, n);
      chk({req, " dark length"}, n, F_OF*CPM, F_OF*CPM);
      run_len(s, 1'b0, 500, n);
      chk({req, " steady after"}, n, 500, 500);
      fx_link = 0; tp_link = 0;
      idle(2);
   endtask

   task automatic t_extend;
      int k, n;
      tp_link = 1;
      idle(5);
      pulse_act(0);
      idle(10);
      pulse_act(0);
      wait_lvl(S_TPL, 1'b1, 2000, k);
      run_len(S_TPL, 1'b1, 2000, n);
      chk("R4 first dark", n, F_OF*CPM, F_OF*CPM);
      run_len(S_TPL, 1'b0, 2000, n);
      chk("R4 repeat lit", n, F_ON*CPM, F_ON*CPM);
      run_len(S_TPL, 1'b1, 2000, n);
      chk("R4 repeat dark", n, F_OF*CPM, F_OF*CPM);
      run_len(S_TPL, 1'b0, 600, n);
      chk("R4 no third period", n, 600, 600);
      tp_link = 0;
      idle(2);
   endtask

   task automatic t_cancel;
      int k, n;
      tp_link = 1;
      idle(3);
      pulse_act(0);
      wait_lvl(S_TPL, 1'b1, 2000, k);
      idle(20);
      tp_link = 0;
      #1;
      chk("R5 drop dark now", led_tp_link_n, 1, 1);
      idle(10);
      tp_link = 1;
      #1;
      chk("R5 return lit now", led_tp_link_n, 0, 0);
      @(negedge clk);
      run_len(S_TPL, 1'b0, 500, n);
      chk("R5 no leftover flash", n, 500, 500);
      tp_link = 0;
      idle(2);
   endtask

   task automatic t_col(input bit fiber, input string req);
      int n;
      int s = fiber ? S_FXD : S_TPD;
      fx_full = 0; tp_full = 0;
      idle(3);
      pulse_col(fiber);
      chk({req, " collision lights"}, pin(s), 0, 0);
      run_len(s, 1'b0, 2000, n);
      chk({req, " lit length"}, n, (F_ON-1)*CPM + 1, F_ON*CPM);
      run_len(s, 1'b1, 500, n);
      chk({req, " dark after"}, n, 500, 500);
      if (!fiber) begin
         tp_full = 1;
         idle(3);
         pulse_col(0);
         run_len(S_TPD, 1'b0, 500, n);
         chk("R6 full collision ignored", n, 500, 500);
         tp_full = 0;
      end
      idle(2);
   endtask

   task automatic t_fef;
      int n;
      @(negedge clk);
      fx_fef = 1;
      @(negedge clk);
      chk("R9 starts lit", led_fef_n, 0, 0);
      run_len(S_FEF, 1'b0, 2000, n);
      chk("R9 first lit", n, (E_ON-1)*CPM + 1, E_ON*CPM);
      run_len(S_FEF, 1'b1, 2000, n);
      chk("R9 dark", n, E_OF*CPM, E_OF*CPM);
      run_len(S_FEF, 1'b0, 2000, n);
      chk("R9 repeat lit", n, E_ON*CPM, E_ON*CPM);
      run_len(S_FEF, 1'b1, 2000, n);
      chk("R9 repeat dark", n, E_OF*CPM, E_OF*CPM);
      idle(30);
      fx_fef = 0;
      #1;
      chk("R9 drop dark now", led_fef_n, 1, 1);
      @(negedge clk);
      run_len(S_FEF, 1'b1, 500, n);
      chk("R9 stays dark", n, 500, 500);
   endtask

   task automatic t_ignored;
      int n;
      tp_link = 0;
      idle(3);
      pulse_act(0);
      idle(5);
      tp_link = 1;
      @(negedge clk);
      run_len(S_TPL, 1'b0, 500, n);
      chk("R10 pulse while down ignored", n, 500, 500);
      tp_link = 0;
      idle(2);
   endtask

   initial begin
      for (int c = 0; c < 200000; c++) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_static();
      t_act(0, "R3");
      t_extend();
      t_cancel();
      t_col(0, "R6");
      t_fef();
      t_ignored();
      t_act(1, "R11 fiber link");
      t_col(1, "R11 fiber dup");
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule